// File: doc/BRIEF.md
# Host Memory Window Decoder with Write Protect

This block sits between a card-style host bus and a local memory bus that is shared by a buffer SRAM and an optional flash device. Each host access is tagged as attribute space or common space. The block decodes that access into a local address, one device select and a write enable. The outputs are registered, so they are valid for one cycle after the clock edge that samples the host request.

When no flash is strapped, the card-information image sits in a packed region of the SRAM. Only even attribute addresses carry image bytes, so the block halves the host address and adds the image base. The region at and above 4000h holds the auto-loaded configuration, and the block silently drops any SRAM write into it. When flash is strapped, the lower attribute window and the upper common window are sent to the flash through an active-low select. A flash write goes through only while the flash-write-enable bit is set. A blocked flash write sets a sticky error flag.

Top module: `hm_win_top`

## Requirements
- R1: Strap low: an attribute access at an even host address A, with A below 2*IMG_BYTES (default 128), selects SRAM at local address 4010h + (A >> 1).
- R2: An attribute access at an odd host address (bit 0 = 1) raises rd_ff_o, asserts no select and produces no write enable, whatever the strap.
- R3: Strap low: an attribute access at or above 2*IMG_BYTES raises rd_ff_o and asserts no select.
- R4: An SRAM-targeted write pulses sram_we_o only when its local address is below 4000h. At or above 4000h, sram_sel_o is still asserted but sram_we_o stays 0.
- R5: Strap low: every common-space access selects SRAM, and the local address equals the host address.
- R6: Strap high: an even attribute address below 4000h, and a common address from 4000h to 1FFFFh, drive flash_sel_no low with the local address equal to the host address. A common address below 4000h selects SRAM.
- R7: Strap high: an attribute access at or above 4000h raises rd_ff_o and asserts no select.
- R8: flash_we_o pulses for a flash-targeted write only when flash_wr_en_i is 1.
- R9: A flash-targeted write with flash_wr_en_i at 0 sets flash_wr_err_o. The flag stays at 1 until reset.
- R10: sram_sel_o high and flash_sel_no low never occur in the same cycle.
- R11: Outputs update on the clock edge that samples host_req_i. If host_req_i was 0 at that edge, acc_valid_o, sram_sel_o, sram_we_o, flash_we_o and rd_ff_o are 0, flash_sel_no is 1 and loc_addr_o is 0.
- R12: During and after reset, all outputs sit in the idle state of R11 and flash_wr_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe, sampled each clock |
| host_attr_i | input | 1 | 1 = attribute space, 0 = common space |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 17 | Host byte address |
| flash_strap_i | input | 1 | 1 = flash present and mapped |
| flash_wr_en_i | input | 1 | Flash write enable configuration bit |
| acc_valid_o | output | 1 | An access was sampled on the last edge |
| loc_addr_o | output | 17 | Local memory address |
| sram_sel_o | output | 1 | SRAM select, active high |
| sram_we_o | output | 1 | SRAM write enable |
| flash_sel_no | output | 1 | Flash select, active low |
| flash_we_o | output | 1 | Flash write enable |
| rd_ff_o | output | 1 | Read returns FFh, no device touched |
| flash_wr_err_o | output | 1 | Sticky blocked-flash-write flag |

## Verification
A wrong decode target shows up at the selects one cycle after the request: a select is asserted where none was expected, the wrong device is chosen, or rd_ff_o is missing. A wrong translation shows up only in loc_addr_o, so the bench compares the full address on every access. A protection fault shows up as a sram_we_o pulse at or above 4000h. A broken sticky flag can stay hidden until the cycle after a blocked flash write, so the bench checks the flag on every following cycle, including idle ones.

// File: rtl/hm_win_pkg.sv
package hm_win_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_SRAM  = 2'd1,
    TGT_FLASH = 2'd2
  } tgt_e;

  localparam int unsigned HM_ADDR_W    = 17;
  localparam int unsigned HM_IMG_BASE  = 'h4010;
  localparam int unsigned HM_PROT_BASE = 'h4000;
  localparam int unsigned HM_FL_SPLIT  = 'h4000;
endpackage

// File: rtl/hm_win_decode.sv
module hm_win_decode
  import hm_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = HM_ADDR_W,
  parameter int unsigned IMG_BYTES = 64,
  parameter int unsigned IMG_BASE  = HM_IMG_BASE,
  parameter int unsigned PROT_BASE = HM_PROT_BASE,
  parameter int unsigned FL_SPLIT  = HM_FL_SPLIT
) (
  input  logic              attr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strap_i,
  input  logic              fl_wr_en_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic              sram_we_o,
  output logic              flash_we_o,
  output logic              wr_err_o
);
  localparam logic [ADDR_W-1:0] ImgSpan  = ADDR_W'(2 * IMG_BYTES);
  localparam logic [ADDR_W-1:0] ImgBase  = ADDR_W'(IMG_BASE);
  localparam logic [ADDR_W-1:0] ProtBase = ADDR_W'(PROT_BASE);
  localparam logic [ADDR_W-1:0] FlSplit  = ADDR_W'(FL_SPLIT);

  tgt_e              tgt;
  logic [ADDR_W-1:0] la;

  always_comb begin
    tgt = TGT_NONE;
    la  = '0;
    if (attr_i && addr_i[0]) begin
      tgt = TGT_NONE;   // odd attribute byte: no storage behind it
    end else if (strap_i) begin
      if (attr_i) begin
        if (addr_i < FlSplit) begin
          tgt = TGT_FLASH;
          la  = addr_i;
        end
      end else begin
        la  = addr_i;
        tgt = (addr_i >= FlSplit) ? TGT_FLASH : TGT_SRAM;
      end
    end else if (attr_i) begin
      if (addr_i < ImgSpan) begin
        tgt = TGT_SRAM;
        la  = ImgBase + (addr_i >> 1);
      end
    end else begin
      tgt = TGT_SRAM;
      la  = addr_i;
    end
  end

  assign tgt_o      = tgt;
  assign loc_addr_o = la;
  assign sram_we_o  = we_i && (tgt == TGT_SRAM) && (la < ProtBase);
  assign flash_we_o = we_i && (tgt == TGT_FLASH) && fl_wr_en_i;
  assign wr_err_o   = we_i && (tgt == TGT_FLASH) && !fl_wr_en_i;
endmodule

// File: rtl/hm_access_reg.sv
module hm_access_reg
  import hm_win_pkg::*;
#(
  parameter int unsigned ADDR_W = HM_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  tgt_e              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sram_we_i,
  input  logic              flash_we_i,
  input  logic              wr_err_i,
  output logic              valid_o,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sram_we_o,
  output logic              flash_we_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      tgt_o      <= TGT_NONE;
      addr_o     <= '0;
      sram_we_o  <= 1'b0;
      flash_we_o <= 1'b0;
    end else if (req_i) begin
      valid_o    <= 1'b1;
      tgt_o      <= tgt_i;
      addr_o     <= addr_i;
      sram_we_o  <= sram_we_i;
      flash_we_o <= flash_we_i;
    end else begin
      valid_o    <= 1'b0;
      tgt_o      <= TGT_NONE;
      addr_o     <= '0;
      sram_we_o  <= 1'b0;
      flash_we_o <= 1'b0;
    end
  end

  // sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_o <= 1'b0;
    else if (req_i && wr_err_i)  err_o <= 1'b1;
  end
endmodule

// File: rtl/hm_win_top.sv
module hm_win_top
  import hm_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = HM_ADDR_W,
  parameter int unsigned IMG_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_attr_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              flash_strap_i,
  input  logic              flash_wr_en_i,
  output logic              acc_valid_o,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic              sram_sel_o,
  output logic              sram_we_o,
  output logic              flash_sel_no,
  output logic              flash_we_o,
  output logic              rd_ff_o,
  output logic              flash_wr_err_o
);
  tgt_e              d_tgt, q_tgt;
  logic [ADDR_W-1:0] d_addr;
  logic              d_swe, d_fwe, d_err;

  hm_win_decode #(
    .ADDR_W   (ADDR_W),
    .IMG_BYTES(IMG_BYTES)
  ) i_decode (
    .attr_i    (host_attr_i),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .strap_i   (flash_strap_i),
    .fl_wr_en_i(flash_wr_en_i),
    .tgt_o     (d_tgt),
    .loc_addr_o(d_addr),
    .sram_we_o (d_swe),
    .flash_we_o(d_fwe),
    .wr_err_o  (d_err)
  );

  hm_access_reg #(
    .ADDR_W(ADDR_W)
  ) i_areg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (host_req_i),
    .tgt_i     (d_tgt),
    .addr_i    (d_addr),
    .sram_we_i (d_swe),
    .flash_we_i(d_fwe),
    .wr_err_i  (d_err),
    .valid_o   (acc_valid_o),
    .tgt_o     (q_tgt),
    .addr_o    (loc_addr_o),
    .sram_we_o (sram_we_o),
    .flash_we_o(flash_we_o),
    .err_o     (flash_wr_err_o)
  );

  assign sram_sel_o   = (q_tgt == TGT_SRAM);
  assign flash_sel_no = (q_tgt != TGT_FLASH);
  assign rd_ff_o      = acc_valid_o && (q_tgt == TGT_NONE);
endmodule

// File: rtl/hm_win_checker.sv
module hm_win_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic              host_attr_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              flash_wr_en_i,
  input logic              acc_valid_o,
  input logic [ADDR_W-1:0] loc_addr_o,
  input logic              sram_sel_o,
  input logic              sram_we_o,
  input logic              flash_sel_no,
  input logic              flash_we_o,
  input logic              rd_ff_o,
  input logic              flash_wr_err_o
);
  a_r10_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_sel_o && !flash_sel_no));

  a_r4_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> (loc_addr_o < ADDR_W'('h4000)));

  a_r8_flash_we_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> ($past(flash_wr_en_i) && $past(host_we_i) && !flash_sel_no));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flash_wr_err_o) |-> flash_wr_err_o);

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && !flash_sel_no && $past(host_we_i) && !$past(flash_wr_en_i))
      |-> flash_wr_err_o);

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(host_req_i) |-> (!acc_valid_o && !sram_sel_o && flash_sel_no &&
                            !sram_we_o && !flash_we_o && !rd_ff_o));

  a_r2_odd_attr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(host_req_i) && $past(host_attr_i) && $past(host_addr_i[0]))
      |-> (rd_ff_o && !sram_sel_o && flash_sel_no));

  a_r3_ff_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ff_o |-> (!sram_sel_o && flash_sel_no && !sram_we_o && !flash_we_o));
endmodule

bind hm_win_top hm_win_checker #(.ADDR_W(ADDR_W)) i_hm_win_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_req_i    (host_req_i),
  .host_attr_i   (host_attr_i),
  .host_we_i     (host_we_i),
  .host_addr_i   (host_addr_i),
  .flash_wr_en_i (flash_wr_en_i),
  .acc_valid_o   (acc_valid_o),
  .loc_addr_o    (loc_addr_o),
  .sram_sel_o    (sram_sel_o),
  .sram_we_o     (sram_we_o),
  .flash_sel_no  (flash_sel_no),
  .flash_we_o    (flash_we_o),
  .rd_ff_o       (rd_ff_o),
  .flash_wr_err_o(flash_wr_err_o)
);

// File: tb/test_hm_win_top.sv
`timescale 1ns/1ps
module test_hm_win_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, attr = 1'b0, we = 1'b0, strap = 1'b0, fen = 1'b0;
  logic [16:0] addr = '0;

  logic        acc_valid, sram_sel, sram_we, flash_sel_n, flash_we, rd_ff, werr;
  logic [16:0] loc_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [23:0] exp_vec;
  bit          m_err;

  always #10 clk = ~clk;

  hm_win_top i_hm_win_top (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_attr_i(attr),
    .host_we_i(we), .host_addr_i(addr), .flash_strap_i(strap),
    .flash_wr_en_i(fen), .acc_valid_o(acc_valid), .loc_addr_o(loc_addr),
    .sram_sel_o(sram_sel), .sram_we_o(sram_we), .flash_sel_no(flash_sel_n),
    .flash_we_o(flash_we), .rd_ff_o(rd_ff), .flash_wr_err_o(werr)
  );

  function automatic logic [23:0] idle_vec(bit e);
    return {1'b0, 17'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, e};
  endfunction

  // behavioural model of one sampled access; 0 none, 1 sram, 2 flash
  task automatic model_edge();
    int t, la;
    bit swe, fwe;
    if (!req) begin
      exp_vec = idle_vec(m_err);
      return;
    end
    t = 0; la = 0;
    if (attr && addr[0]) t = 0;
    else if (strap) begin
      if (attr) begin if (addr < 'h4000) begin t = 2; la = addr; end end
      else begin la = addr; t = (addr >= 'h4000) ? 2 : 1; end
    end else if (attr) begin
      if (addr < 128) begin t = 1; la = 'h4010 + addr / 2; end
    end else begin t = 1; la = addr; end
    swe = we && t == 1 && la < 'h4000;
    fwe = we && t == 2 && fen;
    if (we && t == 2 && !fen) m_err = 1;
    exp_vec = {1'b1, 17'(la), t == 1, swe, t != 2, fwe, t == 0, m_err};
  endtask

  task automatic compare(string req_tag);
    logic [23:0] act;
    act = {acc_valid, loc_addr, sram_sel, sram_we, flash_sel_n, flash_we, rd_ff, werr};
    checks++;
    if (act !== exp_vec) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp_vec);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit r, bit a, bit w, int ad, bit s, bit f, string tag);
    req = r; attr = a; we = w; addr = 17'(ad); strap = s; fen = f;
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic acc(bit a, bit w, int ad, bit s, bit f, string tag);
    step(1, a, w, ad, s, f, tag);
    step(0, 0, 0, 0, 0, 0, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_err = 0;
    exp_vec = idle_vec(0);
    repeat (3) @(negedge clk);
    compare("R12");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R12");
    // R1 image translation
    acc(1, 0, 'h0000, 0, 0, "R1");
    acc(1, 0, 'h0002, 0, 0, "R1");
    acc(1, 0, 'h007e, 0, 0, "R1");
    // R2 odd attribute
    acc(1, 0, 'h0003, 0, 0, "R2");
    acc(1, 1, 'h0001, 1, 1, "R2");
    // R3 outside image
    acc(1, 0, 'h0080, 0, 0, "R3");
    acc(1, 0, 'h1000, 0, 0, "R3");
    // R4 protection
    acc(0, 1, 'h3fff, 0, 0, "R4");
    acc(0, 1, 'h4000, 0, 0, "R4");
    acc(1, 1, 'h0004, 0, 0, "R4");
    acc(0, 1, 'h0100, 1, 0, "R4");
    // R5 common to sram
    acc(0, 0, 'h1abcd, 0, 0, "R5");
    acc(0, 0, 'h05555, 0, 1, "R5");
    // R6 flash map
    acc(1, 0, 'h3ffe, 1, 0, "R6");
    acc(0, 0, 'h4000, 1, 0, "R6");
    acc(0, 0, 'h1ffff, 1, 0, "R6");
    acc(0, 0, 'h3fff, 1, 0, "R6");
    // R7 high attribute with flash
    acc(1, 0, 'h4000, 1, 1, "R7");
    // R8 gated flash write
    acc(0, 1, 'h8000, 1, 1, "R8");
    acc(1, 1, 'h0010, 1, 1, "R8");
    // R9 blocked write sets sticky flag
    acc(0, 1, 'h9000, 1, 0, "R9");
    acc(0, 0, 'h0200, 0, 0, "R9");
    acc(0, 1, 'h9000, 1, 1, "R9");
    // R10/R11 back-to-back accesses
    step(1, 0, 0, 'h5000, 1, 0, "R10");
    step(1, 0, 0, 'h1000, 1, 0, "R10");
    step(1, 1, 0, 'h0006, 0, 0, "R11");
    step(0, 1, 1, 'h0006, 0, 0, "R11");
    // R12 reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    m_err = 0;
    exp_vec = idle_vec(0);
    #2 compare("R12");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule